// File: doc/BRIEF.md
# Dual-Channel Cascadable Pulse Generator

This block makes rectangular waveforms from two 8-bit counting channels. Every channel keeps a low-width value and a high-width value. Its down counter takes these two values in turn. Each time the counter runs out, it reloads and the channel output flips, so the low time and the high time can be set apart from each other. Software writes the four width values and one control byte through a small write port. A per-channel enable input starts and stops each channel.

A mode field in the control byte sets how the two channels combine:

- **Split:** the channels run independently.
- **Prescale:** channel 0 runs freely, and each of its underflows advances channel 1 by one count. This stretches the waveform on pin 1.
- **Wide:** the two counters join into one 16-bit counter, and both pins carry the same waveform.

Each channel can set a sticky interrupt flag on every counter underflow. Software clears the flag by writing the control byte.

Top module: `pulse_pair_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both pulse outputs and both interrupt outputs read 0 until a channel is enabled.
- R2: On the first clock edge that samples a channel's enable high, the channel loads its low-width value and drives its output to 0. The output stays low for low-width + 1 clock ticks and then rises.
- R3: After the first low phase, the output alternates. A high phase lasts high-width + 1 ticks, and a low phase lasts low-width + 1 ticks. Each underflow, from a count of 0, reloads the counter and flips the output. Loading the high value gives a rising edge, and loading the low value gives a falling edge.
- R4: A write to a width register does not change the phase that is running. The new value is used at the next reload of that register.
- R5: One cycle after a channel's enable is sampled low, its output is 0. Enabling it again restarts it as in R2.
- R6: When a channel's interrupt-enable bit is 1, each underflow of that channel sets its interrupt output on the same edge. When the bit is 0, underflows leave the flag unchanged.
- R7: An interrupt flag stays at 1 until software writes the control address with that channel's clear bit set: bit 4 for channel 0, bit 5 for channel 1. If an underflow and a clear happen on the same edge, the flag stays set.
- R8: Mode 0 (control bits [1:0] = 00) is split mode. Pin 0 carries channel 0, pin 1 carries channel 1, and each channel counts one tick per clock.
- R9: Mode 1 (control bits [1:0] = 01) is prescale mode. Channel 0 counts every clock and drives pin 0. Channel 1 counts one tick only on each channel 0 underflow and drives pin 1.
- R10: Mode 2 (control bits [1:0] = 10) is wide mode. The 16-bit low value is {low1, low0} and the 16-bit high value is {high1, high0}. Enable bit 0 controls the pair and enable bit 1 is ignored. Both pins carry the same waveform. The 16-bit underflow sets only interrupt flag 1, under enable bit 3, and flag 0 never sets.
- R11: Register map: address 0 holds channel 0 low width, address 1 channel 0 high width, address 2 channel 1 low width, and address 3 channel 1 high width. Address 4 is control: mode in bits [1:0], interrupt enables in bits 2 (channel 0) and 3 (channel 1), and clear strobes in bits 4 and 5. Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ch_en | input | 2 | Per-channel run enable |
| pulse_o | output | 2 | Pulse output pins |
| irq_o | output | 2 | Per-channel sticky interrupt requests |

## Verification
Every result is registered. A write, an enable change or an underflow on one rising edge shows up at the outputs straight after that edge. A written width value has no effect until the next reload of that register. The bench drives inputs and samples outputs on falling edges. It advances its reference model on each rising edge, using the register contents from before that edge's write. The model's state after the edge is then compared with the pins at the following falling edge. The directed phase-length checks count falling-edge samples, so a phase set to N shows as exactly N + 1 samples.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam int unsigned PPG_CW  = 8;
  localparam int unsigned PPG_AW  = 3;
  localparam int unsigned PPG_NCH = 2;

  typedef enum logic [1:0] {
    MODE_SPLIT     = 2'b00,
    MODE_PRESCALE  = 2'b01,
    MODE_WIDE      = 2'b10,
    MODE_SPLIT_ALT = 2'b11
  } ppg_mode_e;

  localparam int unsigned CTL_IE_LSB  = 2;
  localparam int unsigned CTL_CLR_LSB = 4;
  localparam int unsigned ADDR_CTRL   = 4;

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int unsigned DW  = PPG_CW,
  parameter int unsigned AW  = PPG_AW,
  parameter int unsigned NCH = PPG_NCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  output logic [NCH-1:0][DW-1:0] lo_o,
  output logic [NCH-1:0][DW-1:0] hi_o,
  output ppg_mode_e              mode_o,
  output logic [NCH-1:0]         ie_o,
  output logic [NCH-1:0]         clr_o
);

  logic [NCH-1:0][DW-1:0] lo_q, lo_d, hi_q, hi_d;
  ppg_mode_e              mode_q, mode_d;
  logic [NCH-1:0]         ie_q, ie_d;
  logic                   ctrl_wr;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));
    lo_d    = lo_q;
    hi_d    = hi_q;
    for (int c = 0; c < NCH; c++) begin
      if (wr_en && wr_addr == AW'(2 * c))     lo_d[c] = wr_data;
      if (wr_en && wr_addr == AW'(2 * c + 1)) hi_d[c] = wr_data;
      clr_o[c] = ctrl_wr && wr_data[CTL_CLR_LSB + c];
    end
    mode_d = ctrl_wr ? ppg_mode_e'(wr_data[1:0]) : mode_q;
    ie_d   = ctrl_wr ? wr_data[CTL_IE_LSB +: NCH] : ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= MODE_SPLIT;
      ie_q   <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      mode_q <= mode_d;
      ie_q   <= ie_d;
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign mode_o = mode_q;
  assign ie_o   = ie_q;

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // reload picks up the selected width value
  assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

  // no tick, no movement (prescale gating relies on this)
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/ppg_phase.sv
module ppg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic toggle,
  output logic out_o,
  output logic running_o,
  output logic start_o
);

  logic out_q, out_d, running_q;

  always_comb begin
    start_o = run && !running_q;
    if (!run || start_o) out_d = 1'b0;
    else if (toggle)     out_d = ~out_q;
    else                 out_d = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= 1'b0;
      running_q <= 1'b0;
    end else begin
      out_q     <= out_d;
      running_q <= run;
    end
  end

  assign out_o     = out_q;
  assign running_o = running_q;

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !out_o);

  assert_flip_on_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_o && toggle) |=> (out_o != $past(out_o)));

endmodule

// File: rtl/pulse_pair_gen.sv
module pulse_pair_gen
  import ppg_pkg::*;
#(
  parameter int unsigned CW = PPG_CW,
  parameter int unsigned AW = PPG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    ch_en,
  output logic [1:0]    pulse_o,
  output logic [1:0]    irq_o
);

  localparam int unsigned NCH = PPG_NCH;

  logic [NCH-1:0][CW-1:0] lo, hi, cnt, lval;
  ppg_mode_e              mode;
  logic [NCH-1:0]         ie, clr, eff_en, running, start, out, zero;
  logic [NCH-1:0]         act, borrow, load, dec, tog, set, flag_q, flag_d;
  logic                   wide, presc, tick1, borrow_w;

  ppg_regs #(.DW(CW), .AW(AW), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lo_o(lo), .hi_o(hi), .mode_o(mode),
    .ie_o(ie), .clr_o(clr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    ppg_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load[g]), .load_val(lval[g]),
      .dec(dec[g]), .cnt_o(cnt[g]), .zero_o(zero[g])
    );
    ppg_phase u_phase (
      .clk(clk), .rst_n(rst_n), .run(eff_en[g]), .toggle(tog[g]),
      .out_o(out[g]), .running_o(running[g]), .start_o(start[g])
    );
  end

  always_comb begin
    wide      = (mode == MODE_WIDE);
    presc     = (mode == MODE_PRESCALE);
    eff_en[0] = ch_en[0];
    eff_en[1] = wide ? ch_en[0] : ch_en[1];
    act       = running & eff_en;
    borrow[0] = act[0] && zero[0];
    tick1     = presc ? borrow[0] : 1'b1;
    borrow[1] = act[1] && tick1 && zero[1];
    borrow_w  = act[0] && zero[0] && zero[1];
    if (wide) begin
      for (int c = 0; c < NCH; c++) begin
        load[c] = start[0] || borrow_w;
        lval[c] = (start[0] || out[0]) ? lo[c] : hi[c];
      end
      dec[0] = act[0];
      dec[1] = act[0] && zero[0];
      tog    = {1'b0, borrow_w};
    end else begin
      for (int c = 0; c < NCH; c++) begin
        load[c] = start[c] || borrow[c];
        lval[c] = (start[c] || out[c]) ? lo[c] : hi[c];
      end
      dec[0] = act[0];
      dec[1] = act[1] && tick1;
      tog    = borrow;
    end
    set[0] = !wide && borrow[0] && ie[0];
    set[1] = ie[1] && (wide ? borrow_w : borrow[1]);
    flag_d = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign pulse_o = {(wide ? out[0] : out[1]), out[0]};
  assign irq_o   = flag_q;

  assert_disable_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[0] |=> !pulse_o[0]);

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow[0] && ie[0] && !wide) |=> irq_o[0]);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[1] && !clr[1]) |=> irq_o[1]);

  assert_wide_irq0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !irq_o[0]) |=> !irq_o[0]);

  assert_prescale_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (presc && act[1] && !borrow[0]) |=> $stable(cnt[1]));

endmodule

// File: tb/pulse_pair_gen_test.sv
module pulse_pair_gen_test;

  localparam int CLK_P = 10;

  logic       clk, rst_n, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] ch_en, pulse_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  pulse_pair_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_en(ch_en), .pulse_o(pulse_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // reference model, built from the requirements
  int m_lo[2], m_hi[2], m_rem[2], m_remw, m_mode;
  bit m_run[2], m_out[2], m_flag[2], m_ie[2];

  function automatic int phase_len(int v);
    return v + 1;
  endfunction

  function automatic int wide_val(int b1, int b0);
    return b1 * 256 + b0;
  endfunction

  function automatic bit step_ch(int c, bit en, bit tick);
    if (!en) begin m_run[c] = 0; m_out[c] = 0; return 0; end
    if (!m_run[c]) begin
      m_run[c] = 1; m_out[c] = 0; m_rem[c] = phase_len(m_lo[c]); return 0;
    end
    if (!tick) return 0;
    if (m_rem[c] == 1) begin
      m_out[c] = !m_out[c];
      m_rem[c] = phase_len(m_out[c] ? m_hi[c] : m_lo[c]);
      return 1;
    end
    m_rem[c]--;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit b0, b1, bw, cl0, cl1;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0; m_rem[c] = 0; m_run[c] = 0;
        m_out[c] = 0; m_flag[c] = 0; m_ie[c] = 0;
      end
      m_mode = 0; m_remw = 0;
    end else begin
      b0 = 0; b1 = 0; bw = 0;
      if (m_mode == 2) begin
        if (!ch_en[0]) begin m_run[0] = 0; m_out[0] = 0; end
        else if (!m_run[0]) begin
          m_run[0] = 1; m_out[0] = 0;
          m_remw = phase_len(wide_val(m_lo[1], m_lo[0]));
        end else if (m_remw == 1) begin
          bw = 1; m_out[0] = !m_out[0];
          m_remw = phase_len(m_out[0] ? wide_val(m_hi[1], m_hi[0])
                                      : wide_val(m_lo[1], m_lo[0]));
        end else m_remw--;
        m_run[1] = ch_en[0]; m_out[1] = 0;
      end else begin
        b0 = step_ch(0, ch_en[0], 1'b1);
        b1 = step_ch(1, ch_en[1], (m_mode == 1) ? b0 : 1'b1);
      end
      cl0 = wr_en && wr_addr == 3'd4 && wr_data[4];
      cl1 = wr_en && wr_addr == 3'd4 && wr_data[5];
      m_flag[0] = ((m_mode != 2) && b0 && m_ie[0]) || (m_flag[0] && !cl0);
      m_flag[1] = (m_ie[1] && ((m_mode == 2) ? bw : b1)) || (m_flag[1] && !cl1);
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_lo[0] = int'(wr_data);
          3'd1: m_hi[0] = int'(wr_data);
          3'd2: m_lo[1] = int'(wr_data);
          3'd3: m_hi[1] = int'(wr_data);
          3'd4: begin
            m_mode = int'(wr_data[1:0]); m_ie[0] = wr_data[2]; m_ie[1] = wr_data[3];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_now();
    string tag;
    int exp_pins;
    if (!rst_n) return;
    case (m_mode)
      1: tag = "R9";
      2: tag = "R10";
      3: tag = "R11";
      default: tag = "R8";
    endcase
    exp_pins = (m_mode == 2) ? {30'd0, m_out[0], m_out[0]} : {30'd0, m_out[1], m_out[0]};
    chk(tag, int'(pulse_o), exp_pins, "pins");
    chk("R6", int'(irq_o), {30'd0, m_flag[1], m_flag[0]}, "irq");
  endtask

  task automatic step();
    @(negedge clk);
    check_now();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    step();
    wr_en = 0;
  endtask

  task automatic measure(bit level, output int n);
    n = 0;
    while (pulse_o[0] == level && n < 2000) begin n++; step(); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; ch_en = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", int'(pulse_o), 0, "pins in reset");
    chk("R1", int'(irq_o), 0, "irq in reset");
    rst_n = 1;
    step();
    chk("R1", int'(pulse_o), 0, "pins after reset");

    // directed: phase lengths and write timing in split mode
    wr(0, 2); wr(1, 3);
    ch_en = 2'b01;
    step();
    measure(0, n); chk("R2", n, phase_len(2), "first low length");
    wr(0, 6);
    measure(1, n); chk("R3", n + 1, phase_len(3), "high length");
    measure(0, n); chk("R4", n, phase_len(6), "low after write");
    measure(1, n); chk("R3", n, phase_len(3), "second high length");
    ch_en = 2'b00;
    step();
    chk("R5", int'(pulse_o[0]), 0, "output after disable");
    chk("R6", int'(irq_o[0]), 0, "no flag with enable bit clear");

    // directed: interrupt set, set-wins collision, clear
    wr(0, 0); wr(1, 0); wr(4, 8'h04);
    ch_en = 2'b01;
    step(); step();
    chk("R6", int'(irq_o[0]), 1, "flag after borrow");
    wr(4, 8'h10);
    chk("R7", int'(irq_o[0]), 1, "set wins over clear");
    step();
    wr(4, 8'h10);
    chk("R7", int'(irq_o[0]), 0, "flag cleared");
    ch_en = 2'b00;
    step();

    // random segments, one per mode encoding
    for (int md = 0; md < 4; md++) begin
      ch_en = 2'b00;
      wr(4, md);
      step();
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 150 == 0) ch_en[$urandom % 2] = ~ch_en[$urandom % 2];
        if ($urandom % 6 == 0) begin
          int a, d;
          a = int'($urandom % 5);
          if (a == 4) d = md | (int'($urandom % 16) << 2);
          else if (md == 2 && a >= 2) d = int'($urandom % 2);
          else if (md == 2) d = int'($urandom % 32);
          else if (md == 1 && a < 2) d = int'($urandom % 4);
          else d = int'($urandom % 16);
          wr(a, d);
        end else begin
          step();
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule